// File: doc/BRIEF.md
# Edge-Offset Sample Adaptive Filter

This block corrects reconstructed video samples by the edge-offset rule. For each incoming sample, a direction class picks two of the eight surrounding samples. Each of the two is compared with the centre, and the two comparison results are added to give an edge category. The category is a local minimum, a concave corner, flat, a convex corner or a local maximum. A signed correction is taken from a five-entry offset table by category, added to the centre, and the result is clipped to the range allowed by the active bit depth (10 or 12 bits).

Upstream logic supplies a full 3x3 window around each centre sample, one window per cycle, in raster order. Before each block it pulses `frame_start` to load the direction class, the five offsets and the depth selection. These settings then stay fixed until the next pulse. The filtered samples come out two cycles later with their own valid flag.

Top module: `sao_edge_offset`

## Requirements
- R1: After reset `out_valid` is 0 and `out_sample` is 0.
- R2: `out_valid` equals `in_valid` from exactly two clock cycles earlier, and one window is accepted every cycle with no gaps needed.
- R3: The neighbour pair follows the direction class. Class 0 uses `px_w`/`px_e`, class 1 uses `px_n`/`px_s`, class 2 uses `px_nw`/`px_se`, and class 3 uses `px_ne`/`px_sw`.
- R4: Each neighbour contributes -1 when it is greater than the centre, 0 when equal, and +1 when smaller. The category is the sum of the two contributions (-2..+2).
- R5: Category -2 selects `ofs_e1`, -1 selects `ofs_e2`, 0 selects `ofs_e0`, +1 selects `ofs_e3`, and +2 selects `ofs_e4`.
- R6: Before clipping, the result is the centre plus the selected offset read as 16-bit two's complement. A non-zero `ofs_e0` is applied to flat samples as well.
- R7: A sum below zero gives 0, with no wrap even for offset -32768.
- R8: A sum above the limit gives the limit: 0x3FF when the latched `depth_hi` is 0, 0xFFF when it is 1.
- R9: `dir_class`, the offsets and `depth_hi` are captured only in a cycle with `frame_start` = 1, and that cycle's sample already uses the new values. Changes to them in other cycles have no effect on the output.
- R10: While `out_valid` is 0, `out_sample` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Loads the block configuration this cycle |
| dir_class | input | 2 | Direction class for the neighbour pair |
| ofs_e0 | input | 16 | Signed offset for the flat category |
| ofs_e1 | input | 16 | Signed offset for the local-minimum category |
| ofs_e2 | input | 16 | Signed offset for the concave-corner category |
| ofs_e3 | input | 16 | Signed offset for the convex-corner category |
| ofs_e4 | input | 16 | Signed offset for the local-maximum category |
| depth_hi | input | 1 | 0: 10-bit samples, 1: 12-bit samples |
| in_valid | input | 1 | Window on the `px_*` inputs is valid |
| px_c | input | 12 | Centre sample |
| px_w | input | 12 | Left neighbour |
| px_e | input | 12 | Right neighbour |
| px_n | input | 12 | Neighbour above |
| px_s | input | 12 | Neighbour below |
| px_nw | input | 12 | Upper-left neighbour |
| px_ne | input | 12 | Upper-right neighbour |
| px_sw | input | 12 | Lower-left neighbour |
| px_se | input | 12 | Lower-right neighbour |
| out_valid | output | 1 | Filtered sample valid |
| out_sample | output | 12 | Filtered, clipped sample |

## Verification
For each class the bench makes only the chosen pair larger than the centre and every other neighbour smaller. A design with a swapped direction table then lands on the opposite category and misses by twice the offset. All nine less/equal/greater combinations on one pair are applied with distinct offsets, so a permuted category-to-entry mapping or an inverted sign shows up as a wrong offset. Clipping is probed with a large negative offset on a small sample and with overshoots at both depths. A narrow adder would wrap to a large value instead of giving 0, and a fixed mask would pass 12-bit values in 10-bit mode or cut them in 12-bit mode. The configuration inputs are also changed between `frame_start` pulses, which exposes a design that follows them live instead of holding the latched values.

// File: rtl/sao_edge_offset.sv
module sao_edge_offset #(
  parameter int SW = 12,
  parameter int OW = 16,
  parameter int LO_DEPTH = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic [1:0]           dir_class,
  input  logic signed [OW-1:0] ofs_e0,
  input  logic signed [OW-1:0] ofs_e1,
  input  logic signed [OW-1:0] ofs_e2,
  input  logic signed [OW-1:0] ofs_e3,
  input  logic signed [OW-1:0] ofs_e4,
  input  logic                 depth_hi,
  input  logic                 in_valid,
  input  logic [SW-1:0]        px_c,
  input  logic [SW-1:0]        px_w,
  input  logic [SW-1:0]        px_e,
  input  logic [SW-1:0]        px_n,
  input  logic [SW-1:0]        px_s,
  input  logic [SW-1:0]        px_nw,
  input  logic [SW-1:0]        px_ne,
  input  logic [SW-1:0]        px_sw,
  input  logic [SW-1:0]        px_se,
  output logic                 out_valid,
  output logic [SW-1:0]        out_sample
);

  localparam int SUMW = ((SW > OW) ? SW : OW) + 2;
  localparam logic [SW-1:0] LIM_LO = SW'((1 << LO_DEPTH) - 1);
  localparam logic [SW-1:0] LIM_HI = '1;

  // configuration held for the whole block
  logic [1:0]          cfg_dir;
  logic [4:0][OW-1:0]  cfg_ofs;
  logic                cfg_d12;

  logic [4:0][OW-1:0]  ofs_in;
  assign ofs_in = {ofs_e4, ofs_e3, ofs_e2, ofs_e1, ofs_e0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_dir <= '0;
      cfg_ofs <= '0;
      cfg_d12 <= 1'b0;
    end else if (frame_start) begin
      cfg_dir <= dir_class;
      cfg_ofs <= ofs_in;
      cfg_d12 <= depth_hi;
    end
  end

  // a sample arriving with the load pulse already sees the new settings
  logic [1:0]         dir_use;
  logic [4:0][OW-1:0] ofs_use;
  logic               d12_use;
  assign dir_use = frame_start ? dir_class : cfg_dir;
  assign ofs_use = frame_start ? ofs_in    : cfg_ofs;
  assign d12_use = frame_start ? depth_hi  : cfg_d12;

  logic [SW-1:0] nb_a, nb_b;
  always_comb begin
    case (dir_use)
      2'd0:    begin nb_a = px_w;  nb_b = px_e;  end
      2'd1:    begin nb_a = px_n;  nb_b = px_s;  end
      2'd2:    begin nb_a = px_nw; nb_b = px_se; end
      default: begin nb_a = px_ne; nb_b = px_sw; end
    endcase
  end

  function automatic logic signed [2:0] edge_sign(input logic [SW-1:0] c, input logic [SW-1:0] n);
    if (n > c)      return -3'sd1;
    else if (n < c) return  3'sd1;
    else            return  3'sd0;
  endfunction

  logic signed [2:0] cat;
  assign cat = edge_sign(px_c, nb_a) + edge_sign(px_c, nb_b);

  logic [OW-1:0] ofs_sel;
  always_comb begin
    case (cat)
      3'b110:  ofs_sel = ofs_use[1];
      3'b111:  ofs_sel = ofs_use[2];
      3'b001:  ofs_sel = ofs_use[3];
      3'b010:  ofs_sel = ofs_use[4];
      default: ofs_sel = ofs_use[0];
    endcase
  end

  // stage 1: classified sample
  logic          s1_vld;
  logic [SW-1:0] s1_c;
  logic [OW-1:0] s1_ofs;
  logic          s1_d12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_c   <= '0;
      s1_ofs <= '0;
      s1_d12 <= 1'b0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_c   <= px_c;
        s1_ofs <= ofs_sel;
        s1_d12 <= d12_use;
      end
    end
  end

  // stage 2: add and clip
  logic signed [SUMW-1:0] sum;
  logic signed [SUMW-1:0] lim_ext;
  logic [SW-1:0]          lim;
  logic [SW-1:0]          clipped;

  assign lim     = s1_d12 ? LIM_HI : LIM_LO;
  assign lim_ext = $signed({{(SUMW-SW){1'b0}}, lim});
  assign sum     = $signed({{(SUMW-SW){1'b0}}, s1_c}) + $signed({{(SUMW-OW){s1_ofs[OW-1]}}, s1_ofs});

  always_comb begin
    if (sum < 0)            clipped = '0;
    else if (sum > lim_ext) clipped = lim;
    else                    clipped = SW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) out_sample <= clipped;
    end
  end

endmodule

// File: rtl/sao_edge_offset_chk.sv
module sao_edge_offset_chk #(
  parameter int SW = 12,
  parameter int OW = 16,
  parameter int LO_DEPTH = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               in_valid,
  input logic               out_valid,
  input logic [SW-1:0]      out_sample,
  input logic               s1_d12,
  input logic [1:0]         cfg_dir,
  input logic [4:0][OW-1:0] cfg_ofs,
  input logic               cfg_d12
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2) |-> (out_valid == $past(in_valid, 2)));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && !out_valid) |-> $stable(out_sample));

  a_r8_low_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && out_valid && !$past(s1_d12)) |-> (out_sample <= SW'((1 << LO_DEPTH) - 1)));

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cfg_dir) && $stable(cfg_ofs) && $stable(cfg_d12)));

endmodule

bind sao_edge_offset sao_edge_offset_chk #(.SW(SW), .OW(OW), .LO_DEPTH(LO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .out_valid(out_valid), .out_sample(out_sample), .s1_d12(s1_d12),
  .cfg_dir(cfg_dir), .cfg_ofs(cfg_ofs), .cfg_d12(cfg_d12)
);

// File: tb/sao_edge_offset_tb.sv
`timescale 1ns/1ps
module sao_edge_offset_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, frame_start, depth_hi, in_valid;
  logic [1:0] dir_class;
  logic signed [15:0] ofs_e0, ofs_e1, ofs_e2, ofs_e3, ofs_e4;
  logic [11:0] px_c, px_w, px_e, px_n, px_s, px_nw, px_ne, px_sw, px_se;
  logic out_valid;
  logic [11:0] out_sample;

  sao_edge_offset u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dir_class(dir_class),
    .ofs_e0(ofs_e0), .ofs_e1(ofs_e1), .ofs_e2(ofs_e2), .ofs_e3(ofs_e3), .ofs_e4(ofs_e4),
    .depth_hi(depth_hi), .in_valid(in_valid),
    .px_c(px_c), .px_w(px_w), .px_e(px_e), .px_n(px_n), .px_s(px_s),
    .px_nw(px_nw), .px_ne(px_ne), .px_sw(px_sw), .px_se(px_se),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  int nchk = 0;
  int nerr = 0;

  // bench-side copy of the latched configuration
  int m_dir, m_d12;
  int m_ofs [5];

  // expectation pipeline: index 0 = one step ago, 1 = two steps ago
  bit    p0_v = 0, p1_v = 0;
  int    p0_val = 0, p1_val = 0;
  string p0_tag = "R2", p1_tag = "R2";
  int    last_out = 0;

  task automatic check(input bit ok, input string tag, input int act_v, input int act_d,
                       input int exp_v, input int exp_d);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual valid=%0d data=%0h expected valid=%0d data=%0h",
               tag, act_v, act_d, exp_v, exp_d);
    end
  endtask

  function automatic int sgn(input int c, input int n);
    if (n > c) return -1;
    if (n < c) return 1;
    return 0;
  endfunction

  function automatic int expect_out();
    int a, b, c, cat, idx, s, lim;
    c = px_c;
    case (m_dir)
      0: begin a = px_w;  b = px_e;  end
      1: begin a = px_n;  b = px_s;  end
      2: begin a = px_nw; b = px_se; end
      default: begin a = px_ne; b = px_sw; end
    endcase
    cat = sgn(c, a) + sgn(c, b);
    case (cat)
      -2: idx = 1;
      -1: idx = 2;
      1:  idx = 3;
      2:  idx = 4;
      default: idx = 0;
    endcase
    s = c + m_ofs[idx];
    lim = (m_d12 != 0) ? 4095 : 1023;
    if (s < 0) s = 0;
    if (s > lim) s = lim;
    return s;
  endfunction

  task automatic step(input bit v, input bit fs, input string tag);
    if (p1_v) begin
      check(out_valid === 1'b1 && int'(out_sample) == p1_val, p1_tag,
            int'(out_valid), int'(out_sample), 1, p1_val);
      last_out = p1_val;
    end else begin
      check(out_valid === 1'b0 && int'(out_sample) == last_out, "R2 R10",
            int'(out_valid), int'(out_sample), 0, last_out);
    end
    p1_v = p0_v; p1_val = p0_val; p1_tag = p0_tag;
    in_valid = v;
    frame_start = fs;
    if (fs) begin
      m_dir = int'(dir_class);
      m_d12 = int'(depth_hi);
      m_ofs[0] = ofs_e0; m_ofs[1] = ofs_e1; m_ofs[2] = ofs_e2;
      m_ofs[3] = ofs_e3; m_ofs[4] = ofs_e4;
    end
    p0_v = v;
    p0_val = v ? expect_out() : 0;
    p0_tag = tag;
    @(negedge clk);
  endtask

  task automatic flush();
    repeat (3) step(1'b0, 1'b0, "R2");
  endtask

  task automatic set_cfg(input int d, input bit hi, input int o0, input int o1,
                         input int o2, input int o3, input int o4);
    dir_class = 2'(d); depth_hi = hi;
    ofs_e0 = 16'(o0); ofs_e1 = 16'(o1); ofs_e2 = 16'(o2); ofs_e3 = 16'(o3); ofs_e4 = 16'(o4);
  endtask

  task automatic fill(input int c, input int other);
    px_c = 12'(c);
    px_w = 12'(other); px_e = 12'(other); px_n = 12'(other); px_s = 12'(other);
    px_nw = 12'(other); px_ne = 12'(other); px_sw = 12'(other); px_se = 12'(other);
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0 && out_sample === 12'd0, "R1",
          int'(out_valid), int'(out_sample), 0, 0);
  endtask

  // R3: only the selected pair is larger than the centre
  task automatic t_dirs();
    for (int d = 0; d < 4; d++) begin
      set_cfg(d, 1'b1, 0, 40, 20, -20, -40);
      fill(1000, 900);
      case (d)
        0: begin px_w = 12'd1100;  px_e = 12'd1100;  end
        1: begin px_n = 12'd1100;  px_s = 12'd1100;  end
        2: begin px_nw = 12'd1100; px_se = 12'd1100; end
        default: begin px_ne = 12'd1100; px_sw = 12'd1100; end
      endcase
      step(1'b1, 1'b1, "R3");
    end
    flush();
  endtask

  // R4 R5: every less/equal/greater combination on the horizontal pair
  task automatic t_cats();
    set_cfg(0, 1'b0, 0, 11, 22, -33, -44);
    fill(500, 500);
    step(1'b0, 1'b1, "R5");
    for (int a = -1; a <= 1; a++)
      for (int b = -1; b <= 1; b++) begin
        fill(500, 777);
        px_w = 12'(500 + a * 3);
        px_e = 12'(500 + b * 5);
        step(1'b1, 1'b0, "R4 R5");
      end
    flush();
  endtask

  // R6: entry 0 applied to a flat window
  task automatic t_entry0();
    set_cfg(1, 1'b0, 7, 100, 100, 100, 100);
    fill(300, 300);
    step(1'b1, 1'b1, "R6");
    set_cfg(1, 1'b0, -9, 100, 100, 100, 100);
    step(1'b1, 1'b1, "R6");
    flush();
  endtask

  // R7 R8: clipping at both ends and both depths
  task automatic t_clip();
    set_cfg(0, 1'b0, 0, 100, 0, 0, -100);
    fill(1020, 1022); step(1'b1, 1'b1, "R8");
    fill(5, 3);       step(1'b1, 1'b0, "R7");
    set_cfg(0, 1'b0, -32768, 0, 0, 0, 0);
    fill(0, 0);       step(1'b1, 1'b1, "R7");
    fill(1023, 1023); step(1'b1, 1'b0, "R7");
    set_cfg(0, 1'b1, 0, 200, 0, 0, 0);
    fill(4000, 4050); step(1'b1, 1'b1, "R8");
    fill(1020, 1030); step(1'b1, 1'b0, "R8");
    set_cfg(0, 1'b1, 32767, 0, 0, 0, 0);
    fill(2, 2);       step(1'b1, 1'b1, "R8");
    flush();
  endtask

  // R9: configuration changes without the pulse are ignored
  task automatic t_latch();
    set_cfg(0, 1'b0, 0, 50, 0, 0, 0);
    fill(1000, 1000); px_w = 12'd1010; px_e = 12'd1010;
    step(1'b1, 1'b1, "R9");
    set_cfg(1, 1'b1, 5, -50, 3, 3, 3);
    step(1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, "R9");
    step(1'b1, 1'b1, "R9");
    step(1'b1, 1'b0, "R9");
    flush();
  endtask

  // R2: random windows, back-to-back and with gaps, all classes and depths
  task automatic t_random();
    for (int hi = 0; hi < 2; hi++)
      for (int d = 0; d < 4; d++) begin
        set_cfg(d, hi[0], $urandom_range(0, 8) - 4, $urandom_range(0, 2000) - 1000,
                $urandom_range(0, 400) - 200, $urandom_range(0, 400) - 200,
                $urandom_range(0, 2000) - 1000);
        for (int k = 0; k < 40; k++) begin
          int lim, c;
          lim = hi ? 4095 : 1023;
          c = $urandom_range(0, lim);
          px_c  = 12'(c);
          px_w  = 12'($urandom_range(0, 2) == 0 ? c : $urandom_range(0, lim));
          px_e  = 12'($urandom_range(0, 2) == 0 ? c : $urandom_range(0, lim));
          px_n  = 12'($urandom_range(0, 2) == 0 ? c : $urandom_range(0, lim));
          px_s  = 12'($urandom_range(0, 2) == 0 ? c : $urandom_range(0, lim));
          px_nw = 12'($urandom_range(0, lim));
          px_ne = 12'($urandom_range(0, 2) == 0 ? c : $urandom_range(0, lim));
          px_sw = 12'($urandom_range(0, lim));
          px_se = 12'($urandom_range(0, 2) == 0 ? c : $urandom_range(0, lim));
          step((k % 7) != 3, k == 0, "R2");
        end
      end
    flush();
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0;
    set_cfg(0, 1'b0, 0, 0, 0, 0, 0);
    fill(0, 0);
    m_dir = 0; m_d12 = 0;
    for (int i = 0; i < 5; i++) m_ofs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    flush();
    t_dirs();
    t_cats();
    t_entry0();
    t_clip();
    t_latch();
    t_random();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule